// File: doc/BRIEF.md
# GPIO-to-Sample LSB Streaming Inserter

This block sits in an I/Q sample path and uses the least significant bit of each 16-bit signed sample as a side channel for two GPIO pins. In the receive direction, the synchronized levels of two input pins are written into bit 0 of the outgoing I and Q samples. In the transmit direction, bit 0 of each incoming I and Q sample is taken off to drive two output pins, and that bit is then zeroed in the sample passed on to the next stage.

Each direction has a 2-bit lane enable. Bit 0 of the enable covers the I lane, which is tied to pin 15. Bit 1 covers the Q lane, which is tied to pin 14. A lane that is not enabled passes its samples through untouched. In the transmit direction, a disabled lane also leaves its pin request inactive. The block never sets a pin's direction. Pins that carry receive data must already be configured as inputs. Pins that carry transmit data must already be outputs under software control.

Both directions are valid/ready streams with one register stage, so each has one cycle of latency. Under backpressure no sample is dropped or repeated.

Top module: `gpio_lsb_streamer`

## Requirements
- R1: Receive, I lane enabled (rx_en[0]=1). Bit 0 of the output I sample equals pin 15 as it stood after two synchronizer flops, captured on the clock edge that accepts the input sample.
- R2: Receive, Q lane enabled (rx_en[1]=1). Bit 0 of the output Q sample equals synchronized pin 14, captured the same way as in R1.
- R3: Receive. Bits 15:1 of every sample pass through unchanged. When a lane's enable bit is 0, bit 0 of that lane also passes through unchanged.
- R4: Transmit. When tx_en[0] is 1, bit 0 of the output I sample is 0. When tx_en[1] is 1, bit 0 of the output Q sample is 0. All other bits, and bit 0 of a disabled lane, pass through unchanged.
- R5: Transmit. tx_pin_val[15] holds bit 0 of the I sample most recently accepted while tx_en[0] was 1. tx_pin_val[14] does the same for the Q sample and tx_en[1]. Each value holds until the next accepted sample. A sample accepted while its lane is disabled clears the held value to 0, and the pin value reads 0 whenever its lane is disabled.
- R6: tx_pin_drive[15] equals tx_en[0] and tx_pin_drive[14] equals tx_en[1]. Every other bit of tx_pin_drive and tx_pin_val is 0.
- R7: A sample accepted on one clock edge appears with out_valid high after that edge.
- R8: in_ready is high when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, the output sample holds stable. Samples leave in the order they arrived, with none lost and none duplicated.
- R9: After reset, both out_valid outputs are low and tx_pin_val and tx_pin_drive are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 2 | Receive lane enables: bit0 I, bit1 Q |
| rx_pins | input | 16 | GPIO input pin levels (asynchronous) |
| rx_in_valid | input | 1 | Receive input sample valid |
| rx_in_ready | output | 1 | Receive input ready |
| rx_in_i | input | 16 | Receive input I sample (signed) |
| rx_in_q | input | 16 | Receive input Q sample (signed) |
| rx_out_valid | output | 1 | Receive output valid |
| rx_out_ready | input | 1 | Receive output ready |
| rx_out_i | output | 16 | Receive output I sample with pin 15 inserted |
| rx_out_q | output | 16 | Receive output Q sample with pin 14 inserted |
| tx_en | input | 2 | Transmit lane enables: bit0 I, bit1 Q |
| tx_in_valid | input | 1 | Transmit input valid |
| tx_in_ready | output | 1 | Transmit input ready |
| tx_in_i | input | 16 | Transmit input I sample |
| tx_in_q | input | 16 | Transmit input Q sample |
| tx_out_valid | output | 1 | Transmit output valid |
| tx_out_ready | input | 1 | Transmit output ready |
| tx_out_i | output | 16 | Transmit output I sample, LSB cleared when the lane is enabled |
| tx_out_q | output | 16 | Transmit output Q sample, LSB cleared when the lane is enabled |
| tx_pin_val | output | 16 | Requested GPIO output levels |
| tx_pin_drive | output | 16 | Mask of pins this block is asking to drive |

## Verification
The bench walks through all four enable combinations in each direction while changing the pin levels on every cycle and applying random backpressure. This catches a design that samples pins at the wrong synchronizer depth, or one that crosses the I and Q pins; either would put a neighbouring cycle's or the other lane's level in bit 0. Long stalls expose a design that lets the output register change while it is held, or that loses or repeats samples. Doing accepts while a lane is disabled catches a design that keeps a stale transmit pin value, or that clears the LSB of a lane that is switched off.

// File: rtl/gpio_lsb_streamer.sv
module gpio_lsb_streamer #(
  parameter int SW          = 16,
  parameter int PIN_W       = 16,
  parameter int I_PIN       = 15,
  parameter int Q_PIN       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           rx_en,
  input  logic [PIN_W-1:0]     rx_pins,
  input  logic                 rx_in_valid,
  output logic                 rx_in_ready,
  input  logic signed [SW-1:0] rx_in_i,
  input  logic signed [SW-1:0] rx_in_q,
  output logic                 rx_out_valid,
  input  logic                 rx_out_ready,
  output logic signed [SW-1:0] rx_out_i,
  output logic signed [SW-1:0] rx_out_q,
  input  logic [1:0]           tx_en,
  input  logic                 tx_in_valid,
  output logic                 tx_in_ready,
  input  logic signed [SW-1:0] tx_in_i,
  input  logic signed [SW-1:0] tx_in_q,
  output logic                 tx_out_valid,
  input  logic                 tx_out_ready,
  output logic signed [SW-1:0] tx_out_i,
  output logic signed [SW-1:0] tx_out_q,
  output logic [PIN_W-1:0]     tx_pin_val,
  output logic [PIN_W-1:0]     tx_pin_drive
);

  // two pins only: index 1 = I-lane pin, index 0 = Q-lane pin
  logic [SYNC_STAGES-1:0][1:0] sync_q;
  logic [1:0] pin_now;
  logic       rx_acc, tx_acc;
  logic [1:0] tx_hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_pins[I_PIN], rx_pins[Q_PIN]};

  assign pin_now = sync_q[SYNC_STAGES-1];

  // receive lane
  assign rx_in_ready = !rx_out_valid || rx_out_ready;
  assign rx_acc      = rx_in_valid && rx_in_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_out_valid <= 1'b0;
      rx_out_i     <= '0;
      rx_out_q     <= '0;
    end else if (rx_acc) begin
      rx_out_valid <= 1'b1;
      rx_out_i     <= {rx_in_i[SW-1:1], rx_en[0] ? pin_now[1] : rx_in_i[0]};
      rx_out_q     <= {rx_in_q[SW-1:1], rx_en[1] ? pin_now[0] : rx_in_q[0]};
    end else if (rx_out_ready) begin
      rx_out_valid <= 1'b0;
    end

  // transmit lane
  assign tx_in_ready = !tx_out_valid || tx_out_ready;
  assign tx_acc      = tx_in_valid && tx_in_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_out_valid <= 1'b0;
      tx_out_i     <= '0;
      tx_out_q     <= '0;
      tx_hold      <= '0;
    end else if (tx_acc) begin
      tx_out_valid <= 1'b1;
      tx_out_i     <= {tx_in_i[SW-1:1], tx_in_i[0] & ~tx_en[0]};
      tx_out_q     <= {tx_in_q[SW-1:1], tx_in_q[0] & ~tx_en[1]};
      tx_hold      <= {tx_in_i[0] & tx_en[0], tx_in_q[0] & tx_en[1]};
    end else if (tx_out_ready) begin
      tx_out_valid <= 1'b0;
    end

  always_comb begin
    tx_pin_val          = '0;
    tx_pin_drive        = '0;
    tx_pin_val[I_PIN]   = tx_hold[1] & tx_en[0];
    tx_pin_val[Q_PIN]   = tx_hold[0] & tx_en[1];
    tx_pin_drive[I_PIN] = tx_en[0];
    tx_pin_drive[Q_PIN] = tx_en[1];
  end

  p_rx_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_acc |=> rx_out_valid);
  p_tx_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_acc |=> tx_out_valid);
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_ready |=> rx_out_valid && $stable(rx_out_i) && $stable(rx_out_q));
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_i) && $stable(tx_out_q));
  p_rx_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_acc |=> rx_out_i[SW-1:1] == $past(rx_in_i[SW-1:1]) && rx_out_q[SW-1:1] == $past(rx_in_q[SW-1:1]));
  p_rx_ipin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_acc && rx_en[0] |=> rx_out_i[0] == $past(pin_now[1]));
  p_rx_qpin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_acc && rx_en[1] |=> rx_out_q[0] == $past(pin_now[0]));
  p_tx_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_acc && tx_en[0] |=> tx_out_i[0] == 1'b0);
  p_tx_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_acc && tx_en[0] && $stable(tx_en) |=> tx_pin_val[I_PIN] == ($past(tx_in_i[0]) & tx_en[0]));

endmodule

// File: tb/gpio_lsb_streamer_tb.sv
`timescale 1ns/1ps
module gpio_lsb_streamer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rx_en = 0, tx_en = 0;
  logic [15:0] rx_pins = 0;
  logic rx_in_valid = 0, rx_out_ready = 0, tx_in_valid = 0, tx_out_ready = 0;
  logic signed [15:0] rx_in_i = 0, rx_in_q = 0, tx_in_i = 0, tx_in_q = 0;
  logic rx_in_ready, rx_out_valid, tx_in_ready, tx_out_valid;
  logic signed [15:0] rx_out_i, rx_out_q, tx_out_i, tx_out_q;
  logic [15:0] tx_pin_val, tx_pin_drive;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_lsb_streamer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_pins(rx_pins),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_i(rx_in_i), .rx_in_q(rx_in_q),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_i(rx_out_i), .rx_out_q(rx_out_q),
    .tx_en(tx_en), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_i(tx_in_i), .tx_in_q(tx_in_q),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_i(tx_out_i), .tx_out_q(tx_out_q),
    .tx_pin_val(tx_pin_val), .tx_pin_drive(tx_pin_drive));

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model state
  logic [15:0] qr_i[$], qr_q[$], qt_i[$], qt_q[$];
  bit          qr_ei[$], qr_eq[$];
  logic [1:0]  m_s1 = 0, m_s2 = 0, m_hold = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [15:0] ei, eq, ev, ed;
      bit ra, rb, ta, tb;
      // receive
      chk(rx_in_ready == (qr_i.size() == 0 || rx_out_ready), "R8", "rx_in_ready", rx_in_ready, qr_i.size() == 0 || rx_out_ready);
      chk(rx_out_valid == (qr_i.size() > 0), "R7", "rx_out_valid", rx_out_valid, qr_i.size() > 0);
      if (rx_out_valid && qr_i.size() > 0) begin
        chk(rx_out_i[15:1] == qr_i[0][15:1] && rx_out_q[15:1] == qr_q[0][15:1], "R3", "rx upper bits",
            {rx_out_i, rx_out_q}, {qr_i[0], qr_q[0]});
        chk(rx_out_i[0] == qr_i[0][0], qr_ei[0] ? "R1" : "R3", "rx I lsb", rx_out_i[0], qr_i[0][0]);
        chk(rx_out_q[0] == qr_q[0][0], qr_eq[0] ? "R2" : "R3", "rx Q lsb", rx_out_q[0], qr_q[0][0]);
      end
      // transmit
      chk(tx_in_ready == (qt_i.size() == 0 || tx_out_ready), "R8", "tx_in_ready", tx_in_ready, qt_i.size() == 0 || tx_out_ready);
      chk(tx_out_valid == (qt_i.size() > 0), "R7", "tx_out_valid", tx_out_valid, qt_i.size() > 0);
      if (tx_out_valid && qt_i.size() > 0)
        chk(tx_out_i == qt_i[0] && tx_out_q == qt_q[0], "R4", "tx sample", {tx_out_i, tx_out_q}, {qt_i[0], qt_q[0]});
      ev = '0; ev[15] = m_hold[1] & tx_en[0]; ev[14] = m_hold[0] & tx_en[1];
      ed = '0; ed[15] = tx_en[0]; ed[14] = tx_en[1];
      chk(tx_pin_val == ev, "R5", "tx_pin_val", tx_pin_val, ev);
      chk(tx_pin_drive == ed, "R6", "tx_pin_drive", tx_pin_drive, ed);
      // advance model across the coming edge
      ra = rx_in_valid && (qr_i.size() == 0 || rx_out_ready);
      rb = rx_out_valid && rx_out_ready;
      ta = tx_in_valid && (qt_i.size() == 0 || tx_out_ready);
      tb = tx_out_valid && tx_out_ready;
      if (rb && qr_i.size() > 0) begin
        void'(qr_i.pop_front()); void'(qr_q.pop_front()); void'(qr_ei.pop_front()); void'(qr_eq.pop_front());
      end
      if (ra) begin
        ei = rx_in_i; eq = rx_in_q;
        if (rx_en[0]) ei[0] = m_s2[1];
        if (rx_en[1]) eq[0] = m_s2[0];
        qr_i.push_back(ei); qr_q.push_back(eq); qr_ei.push_back(rx_en[0]); qr_eq.push_back(rx_en[1]);
      end
      if (tb && qt_i.size() > 0) begin
        void'(qt_i.pop_front()); void'(qt_q.pop_front());
      end
      if (ta) begin
        ei = tx_in_i; eq = tx_in_q;
        if (tx_en[0]) ei[0] = 1'b0;
        if (tx_en[1]) eq[0] = 1'b0;
        qt_i.push_back(ei); qt_q.push_back(eq);
        m_hold = {tx_in_i[0] & tx_en[0], tx_in_q[0] & tx_en[1]};
      end
      m_s2 = m_s1;
      m_s1 = {rx_pins[15], rx_pins[14]};
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(rx_out_valid == 0 && tx_out_valid == 0, "R9", "valids in reset", {rx_out_valid, tx_out_valid}, 0);
    chk(tx_pin_val == 0 && tx_pin_drive == 0, "R9", "pins in reset", {tx_pin_val, tx_pin_drive}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(rx_out_valid == 0 && tx_out_valid == 0 && tx_pin_val == 0, "R9", "state after reset",
        {rx_out_valid, tx_out_valid, tx_pin_val}, 0);
    for (int ph = 0; ph < 16; ph++) begin
      rx_en = ph[1:0]; tx_en = ph[3:2];
      for (int c = 0; c < 150; c++) begin
        @(posedge clk); #1;
        rx_pins      = 16'($urandom);
        rx_in_valid  = ($urandom % 4) != 0;
        rx_out_ready = (ph % 4 == 3) ? (($urandom % 5) == 0) : (($urandom % 3) != 0);
        tx_in_valid  = ($urandom % 4) != 0;
        tx_out_ready = (ph % 4 == 2) ? (($urandom % 5) == 0) : (($urandom % 3) != 0);
        if (rx_in_ready || !rx_in_valid) begin rx_in_i = 16'($urandom); rx_in_q = 16'($urandom); end
        if (tx_in_ready || !tx_in_valid) begin tx_in_i = 16'($urandom); tx_in_q = 16'($urandom); end
      end
    end
    rx_in_valid = 0; tx_in_valid = 0; rx_out_ready = 1; tx_out_ready = 1;
    repeat (5) @(posedge clk);
    @(negedge clk); #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule